// File: doc/BRIEF.md
# Hybrid Counter and Phase-Edge Pulse Width Modulator

This block turns a binary duty word into one pulse-width-modulated output whose width can be set more finely than one period of its logic clock. A counter on the reference clock sets a coarse pulse that lasts a whole number of clock periods. A second clock, which is the same frequency as the reference but delayed by a selectable fraction of a period, then stretches that pulse. The stretch comes from re-capturing the coarse pulse on either the rising or the falling edge of the delayed clock and OR-ing the captured copy onto the coarse pulse.

The low bits of the duty word pick the delay. The block does not make or switch clocks. It holds the low field and presents it on an output, so that an outside selector can route the matching delayed clock to `clk_phase`. With a phase step of Tc/2^(P+1), where P is the width of the low field, the output width is the upper field times Tc plus the value of the lower P+1 bits times Tc/2^(P+1).

Top module: `hrpwm_core`

## Requirements
- R1: While `rst_n` is low, the carrier counter, the held duty fields, `phase_sel` and `pwm_out` are all zero.
- R2: The carrier counter counts 0, 1, ..., PERIOD_CNT-1 on rising edges of `clk_ref` and then returns to 0. Successive output pulses start exactly PERIOD_CNT reference periods apart.
- R3: Bits [DUTY_W-1:P+1] form the coarse field C. The reference pulse is high for the count values below C, which makes it exactly C reference periods wide.
- R4: `duty_word` is captured only in the cycle where the counter wraps. A change in mid-period does not alter the pulse in progress, and it does not alter `phase_sel`.
- R5: When bit P (the edge bit) is 0, the coarse pulse is captured on rising edges of `clk_phase`, and the falling-edge capture stays low.
- R6: When bit P is 1, the coarse pulse is captured on falling edges of `clk_phase`, and the rising-edge capture stays low.
- R7: `pwm_out` is the coarse pulse ORed with both captures. Its high time is C*Tc + duty_word[P:0]*Tc/2^(P+1) when `clk_phase` lags `clk_ref` by `phase_sel`*Tc/2^(P+1).
- R8: When C is 0, `pwm_out` stays low whatever the edge bit and the low field hold.
- R9: When C is PERIOD_CNT or larger, `pwm_out` stays high through the whole period. C = PERIOD_CNT-1 still gives a pulse with a short low gap.
- R10: `phase_sel` carries the held bits [P-1:0] of the duty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference (0 degree) clock for the counter and the coarse pulse |
| clk_phase | input | 1 | Externally selected delayed copy of the reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_word | input | DUTY_W | Duty word: coarse field, edge bit, phase field |
| pwm_out | output | 1 | High-resolution PWM output |
| phase_sel | output | PHASE_BITS | Held phase field that drives the outside clock selector |

## Verification
The bench sweeps the duty word across every combination of edge bit and phase field for coarse values 1 to 7, and measures each high time against the width formula to the picosecond. A swapped edge choice would give widths off by half a period, and a wrong field split would give widths off by whole periods. It changes the duty word in the middle of a pulse and expects both the old width and the old `phase_sel`. A design that latched the word immediately would shorten or lengthen that pulse. It also tests a coarse field of zero, which must give no pulse even if a fine capture misbehaves. It tests coarse values at or just below the period length, which must give a constant high output or a pulse with a single short gap, and a faulty comparator width would break either one.

// File: rtl/hrpwm_pkg.sv
`timescale 1ps/1ps
package hrpwm_pkg;
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;
endpackage

// File: rtl/hrpwm_carrier.sv
`timescale 1ps/1ps
module hrpwm_carrier #(
   parameter int PERIOD_CNT = 200,
   localparam int CNT_W = $clog2(PERIOD_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CNT - 1);

   assign wrap = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (wrap)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/hrpwm_coarse.sv
`timescale 1ps/1ps
module hrpwm_coarse
   import hrpwm_pkg::*;
#(
   parameter int DUTY_W     = 12,
   parameter int PHASE_BITS = 3,
   parameter int CNT_W      = 8,
   localparam int COARSE_W  = DUTY_W - PHASE_BITS - 1,
   localparam int CMP_W     = ((COARSE_W > CNT_W) ? COARSE_W : CNT_W) + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wrap,
   input  logic [CNT_W-1:0]      cnt,
   input  logic [DUTY_W-1:0]     duty_word,
   output logic                  ref_pulse,
   output logic [COARSE_W-1:0]   coarse_val,
   output edge_sel_e             edge_sel,
   output logic [PHASE_BITS-1:0] phase_idx
);
   // Fields are held for a whole period; they load only at wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_val <= '0;
         edge_sel   <= EDGE_RISE;
         phase_idx  <= '0;
      end else if (wrap) begin
         coarse_val <= duty_word[DUTY_W-1:PHASE_BITS+1];
         edge_sel   <= edge_sel_e'(duty_word[PHASE_BITS]);
         phase_idx  <= duty_word[PHASE_BITS-1:0];
      end
   end

   // Registered comparator: a clean edge aligned to the reference clock.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ref_pulse <= 1'b0;
      else        ref_pulse <= (CMP_W'(coarse_val) > CMP_W'(cnt));
   end
endmodule

// File: rtl/hrpwm_fine.sv
`timescale 1ps/1ps
module hrpwm_fine
   import hrpwm_pkg::*;
(
   input  logic      clk_phase,
   input  logic      rst_n,
   input  logic      ref_pulse,
   input  edge_sel_e edge_sel,
   output logic      rise_q,
   output logic      fall_q
);
   logic rise_d, fall_d;

   // Edge selection is done on the data side, ahead of the flops.
   always_comb begin
      rise_d = ref_pulse & (edge_sel == EDGE_RISE);
      fall_d = ref_pulse & (edge_sel == EDGE_FALL);
   end

   always_ff @(posedge clk_phase or negedge rst_n) begin
      if (!rst_n) rise_q <= 1'b0;
      else        rise_q <= rise_d;
   end

   always_ff @(negedge clk_phase or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= fall_d;
   end
endmodule

// File: rtl/hrpwm_core.sv
`timescale 1ps/1ps
module hrpwm_core
   import hrpwm_pkg::*;
#(
   parameter int DUTY_W     = 12,
   parameter int PHASE_BITS = 3,
   parameter int PERIOD_CNT = 200,
   localparam int CNT_W     = $clog2(PERIOD_CNT),
   localparam int COARSE_W  = DUTY_W - PHASE_BITS - 1
) (
   input  logic                  clk_ref,
   input  logic                  clk_phase,
   input  logic                  rst_n,
   input  logic [DUTY_W-1:0]     duty_word,
   output logic                  pwm_out,
   output logic [PHASE_BITS-1:0] phase_sel
);
   generate
      if (PHASE_BITS < 1) begin : g_bad_phase
         $error("hrpwm_core: PHASE_BITS must be at least 1");
      end
      if (DUTY_W < PHASE_BITS + 2) begin : g_bad_duty
         $error("hrpwm_core: DUTY_W leaves no coarse field");
      end
      if (PERIOD_CNT < 2) begin : g_bad_period
         $error("hrpwm_core: PERIOD_CNT must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]    cnt;
   logic                wrap;
   logic                ref_pulse;
   logic [COARSE_W-1:0] coarse_val;
   edge_sel_e           edge_sel;
   logic                rise_q, fall_q;

   hrpwm_carrier #(.PERIOD_CNT(PERIOD_CNT)) u_carrier (
      .clk(clk_ref), .rst_n(rst_n), .cnt(cnt), .wrap(wrap)
   );

   hrpwm_coarse #(.DUTY_W(DUTY_W), .PHASE_BITS(PHASE_BITS), .CNT_W(CNT_W)) u_coarse (
      .clk(clk_ref), .rst_n(rst_n), .wrap(wrap), .cnt(cnt),
      .duty_word(duty_word), .ref_pulse(ref_pulse), .coarse_val(coarse_val),
      .edge_sel(edge_sel), .phase_idx(phase_sel)
   );

   hrpwm_fine u_fine (
      .clk_phase(clk_phase), .rst_n(rst_n), .ref_pulse(ref_pulse),
      .edge_sel(edge_sel), .rise_q(rise_q), .fall_q(fall_q)
   );

   assign pwm_out = ref_pulse | rise_q | fall_q;
endmodule

// File: rtl/hrpwm_core_chk.sv
`timescale 1ps/1ps
module hrpwm_core_chk #(
   parameter int PERIOD_CNT = 200,
   parameter int CNT_W      = 8,
   parameter int COARSE_W   = 8,
   parameter int PHASE_BITS = 3
) (
   input logic                  clk_ref,
   input logic                  rst_n,
   input logic [CNT_W-1:0]      cnt,
   input logic                  wrap,
   input logic                  ref_pulse,
   input logic [COARSE_W-1:0]   coarse_val,
   input logic                  edge_bit,
   input logic [PHASE_BITS-1:0] phase_sel,
   input logic                  rise_q,
   input logic                  fall_q,
   input logic                  pwm_out
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CNT - 1);
   localparam int CMP_W = ((COARSE_W > CNT_W) ? COARSE_W : CNT_W) + 1;

   assert_reset_clear_R1: assert property (@(posedge clk_ref)
      !rst_n |=> (cnt == '0) && !ref_pulse && (phase_sel == '0));

   assert_count_step_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

   assert_count_wrap_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (cnt == LAST) |=> (cnt == '0));

   assert_hold_stable_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !wrap |=> $stable(coarse_val) && $stable(edge_bit) && $stable(phase_sel));

   assert_rise_only_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!edge_bit && $stable(edge_bit)) |-> !fall_q);

   assert_fall_only_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (edge_bit && $stable(edge_bit)) |-> !rise_q);

   assert_zero_coarse_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ((coarse_val == '0) && $stable(coarse_val)) |-> !pwm_out);

   assert_full_coarse_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ((CMP_W'(coarse_val) >= CMP_W'(PERIOD_CNT)) && $stable(coarse_val)) |-> pwm_out);
endmodule

bind hrpwm_core hrpwm_core_chk #(
   .PERIOD_CNT(PERIOD_CNT), .CNT_W(CNT_W), .COARSE_W(COARSE_W), .PHASE_BITS(PHASE_BITS)
) u_chk (
   .clk_ref(clk_ref), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .ref_pulse(ref_pulse),
   .coarse_val(coarse_val), .edge_bit(edge_sel), .phase_sel(phase_sel),
   .rise_q(rise_q), .fall_q(fall_q), .pwm_out(pwm_out)
);

// File: tb/hrpwm_core_test.sv
`timescale 1ps/1ps
module hrpwm_core_test;
   localparam int CLK_PERIOD = 4800;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int PBITS      = 3;
   localparam int STEP       = CLK_PERIOD / (2 ** (PBITS + 1));
   localparam int PERIOD     = 200;
   localparam int DW         = 12;
   localparam int GUARD      = 1;

   logic clk_ref = 1'b0;
   logic clk_phase = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] duty_word = '0;
   logic pwm_out;
   logic [PBITS-1:0] phase_sel;

   int n_checks = 0;
   int n_fail = 0;

   typedef struct { longint width; string req; } exp_t;
   exp_t exp_q[$];

   hrpwm_core #(.DUTY_W(DW), .PHASE_BITS(PBITS), .PERIOD_CNT(PERIOD)) uut (
      .clk_ref(clk_ref), .clk_phase(clk_phase), .rst_n(rst_n),
      .duty_word(duty_word), .pwm_out(pwm_out), .phase_sel(phase_sel)
   );

   always #(HALF) clk_ref = ~clk_ref;

   // Stand-in for the outside clock selector: a copy delayed by phase_sel steps.
   always begin
      @(posedge clk_ref);
      #(GUARD);
      #(int'(phase_sel) * STEP);
      clk_phase = 1'b1;
      #(HALF);
      clk_phase = 1'b0;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic longint width_of(input logic [DW-1:0] d);
      return longint'(d[DW-1:PBITS+1]) * CLK_PERIOD + longint'(d[PBITS:0]) * STEP + GUARD;
   endfunction

   // Monitor: pairs each measured pulse with the expected item queued before it rose.
   initial begin
      forever begin
         longint t_rise;
         bit have;
         exp_t e;
         @(posedge pwm_out);
         t_rise = $time;
         have = (exp_q.size() > 0);
         if (have) e = exp_q.pop_front();
         @(negedge pwm_out);
         if (have) chk(($time - t_rise) == e.width, e.req, $time - t_rise, e.width);
      end
   end

   task automatic settle();
      repeat (PERIOD + 10) @(posedge clk_ref);
   endtask

   task automatic expect_pulse(input logic [DW-1:0] d, input string req);
      exp_t e;
      e.width = width_of(d);
      e.req = req;
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
      @(negedge pwm_out);
      #1;
   endtask

   task automatic count_high(output int highs);
      highs = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk_ref);
         if (pwm_out) highs++;
      end
   endtask

   initial begin
      #(longint'(CLK_PERIOD) * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int highs;
      longint t1, t2;
      duty_word = 12'd85;
      repeat (5) @(negedge clk_ref);
      // R1: everything low while reset is held
      chk(pwm_out == 1'b0, "R1", pwm_out, 0);
      chk(phase_sel == '0, "R1", phase_sel, 0);
      rst_n = 1'b1;

      // R7/R3/R5: the worked example, coarse 5, rising edge, phase 5
      settle();
      chk(phase_sel == 3'd5, "R10", phase_sel, 5);
      expect_pulse(12'd85, "R7");

      // R2: pulse starts are PERIOD reference cycles apart
      @(posedge pwm_out); t1 = $time;
      @(posedge pwm_out); t2 = $time;
      chk((t2 - t1) == longint'(PERIOD) * CLK_PERIOD, "R2", t2 - t1, longint'(PERIOD) * CLK_PERIOD);

      // R3 R5 R6 R7: sweep of every edge bit and phase value for coarse 1..7
      for (int d = 16; d < 128; d++) begin
         duty_word = DW'(d);
         settle();
         expect_pulse(DW'(d), d[PBITS] ? "R6" : "R5");
      end

      // R4: mid-pulse change leaves the current pulse and phase_sel alone
      duty_word = 12'd55;
      settle();
      begin
         exp_t e;
         e.width = width_of(12'd55);
         e.req = "R4";
         exp_q.push_back(e);
      end
      @(posedge pwm_out);
      #10 duty_word = 12'd102;
      @(negedge clk_ref);
      chk(phase_sel == 3'd7, "R4", phase_sel, 7);
      @(negedge pwm_out);
      #1;
      begin
         exp_t e;
         e.width = width_of(12'd102);
         e.req = "R4";
         exp_q.push_back(e);
      end
      wait (exp_q.size() == 0);
      @(negedge pwm_out);
      #1;
      chk(phase_sel == 3'd6, "R10", phase_sel, 6);

      // R8: coarse field zero gives no pulse, for both edge choices
      duty_word = 12'd13;
      settle();
      count_high(highs);
      chk(highs == 0, "R8", highs, 0);
      duty_word = 12'd7;
      settle();
      count_high(highs);
      chk(highs == 0, "R8", highs, 0);

      // R9: coarse one below the period still pulses; at or above it stays high
      duty_word = DW'((PERIOD - 1) * 16 + 3);
      settle();
      expect_pulse(DW'((PERIOD - 1) * 16 + 3), "R9");
      duty_word = DW'(PERIOD * 16);
      settle();
      count_high(highs);
      chk(highs == PERIOD, "R9", highs, PERIOD);
      duty_word = DW'(255 * 16 + 15);
      settle();
      count_high(highs);
      chk(highs == PERIOD, "R9", highs, PERIOD);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule